// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block turns one warp-wide load or store into the fewest memory transactions its grouping rules allow. A request carries 32 per-lane byte addresses, an active-lane mask, an element-size code and three cache flags. The block latches the request, splits the lanes into contiguous groups, and merges the active lanes of a group that land in the same aligned segment into one transaction. Before a transaction is sent, the block checks which half of the segment is touched and narrows the transaction to that half. It repeats this check until the transaction is 32 bytes or both halves are in use.

Transactions leave one per cycle on a valid/ready port. Each one carries an aligned address, a size in bytes, the lanes it serves and a byte mask relative to its own address. A done flag marks the last transaction of the warp. While a warp is still draining, `busy_o` is high and new requests are refused.

Group width depends on the mode. Byte-sized elements always use one group of all lanes. Fixed-split mode cuts the warp into `LEGACY_PARTS` equal groups. Cache-aware mode uses `UNCACHED_PARTS` groups for accesses that skip the L1 cache and one group for cached ones.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `busy_o` and `txn_valid_o` are low.
- R2: The segment size before narrowing depends on `req_elem_i`: code 0 (1-byte elements) gives 32 bytes, code 1 (2 bytes) gives 64 bytes, and codes 2 (4 bytes) and 3 (8 bytes) give 128 bytes. A lane's segment base is its address with the low log2(segment) bits cleared.
- R3: With element code 0, all 32 lanes form one group, whatever the mode inputs are.
- R4: With `req_cache_aware_i` low and an element wider than 1 byte, the lanes are split into `LEGACY_PARTS` contiguous groups. The default of 2 gives two groups of 16 lanes.
- R5: With `req_cache_aware_i` high, the access is uncached when `req_l1_bypass_i` or `req_cop_global_i` is high. An uncached access uses `UNCACHED_PARTS` groups, 4 groups of 8 lanes by default.
- R6: With `req_cache_aware_i` high and both bypass inputs low, all lanes form one group.
- R7: Active lanes of one group that share a segment base produce one transaction. Its `txn_lanes_o` bit i is set for each such lane i. Its `txn_bytes_o` bit k is set exactly when byte `txn_addr_o`+k is covered by one of those lanes, where each lane covers element-size bytes from its own address.
- R8: If only one half of a segment larger than 32 bytes is touched, the transaction shrinks to that half, and the address advances by the half size when the upper half is the one used. This repeats down to 32 bytes. `txn_addr_o` is always aligned to `txn_size_o`.
- R9: Inactive lanes never affect any transaction. A group with no active lanes produces no transaction. A request with no active lanes produces none and leaves `busy_o` low.
- R10: Transactions come out in ascending order of the lowest lane they serve.
- R11: `txn_done_o` is high together with the warp's last transaction and at no other time.
- R12: While `txn_valid_o` is high and `txn_ready_i` is low, every transaction output holds its value. With `txn_ready_i` high, one transaction is taken per cycle.
- R13: A request is latched only when `req_valid_i` is high and `busy_o` is low; a request made while busy is dropped. `busy_o` rises the cycle after a non-empty request is latched and falls after the last handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Warp request strobe |
| req_addr_i | input | LANES*AW | Byte address per lane, lane i at bits [i*AW +: AW] |
| req_active_i | input | LANES | Active-lane mask |
| req_elem_i | input | 2 | Element size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_cache_aware_i | input | 1 | 0: fixed split, 1: cache-aware split |
| req_l1_bypass_i | input | 1 | Global setting that sends accesses around the L1 cache |
| req_cop_global_i | input | 1 | The instruction's cache operator marks it as global-level only |
| busy_o | output | 1 | Warp in progress; requests refused |
| txn_valid_o | output | 1 | Transaction available |
| txn_ready_i | input | 1 | Consumer takes the transaction |
| txn_addr_o | output | AW | Transaction byte address, aligned to its size |
| txn_size_o | output | 8 | Transaction size in bytes (32, 64 or 128) |
| txn_lanes_o | output | LANES | Lanes served |
| txn_bytes_o | output | 128 | Touched bytes, bit k = txn_addr_o + k |
| txn_done_o | output | 1 | Last transaction of the warp |

## Verification
The bench builds the block with its defaults: 32 lanes, 32-bit addresses, a fixed split of 2 and an uncached split of 4. With these values, group boundaries fall at lanes 8, 16 and 24, so the half-warp and quarter-warp cases can be told apart on the same linear address pattern. Narrowing is exercised both once (128 to 64) and twice (128 to 32 at a shifted address). The directed cases also cover a warp whose active lanes skip whole groups and a refused request that arrives during backpressure.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int MIN_SEG_LG = 5;
  localparam int MAX_SEG_LG = 7;
  localparam int SEG_BYTES  = 1 << MAX_SEG_LG;

  typedef enum logic [1:0] {
    ELEM_B1 = 2'd0,
    ELEM_B2 = 2'd1,
    ELEM_B4 = 2'd2,
    ELEM_B8 = 2'd3
  } elem_e;

  function automatic logic [2:0] seg_lg_of(elem_e e);
    case (e)
      ELEM_B1: return 3'(MIN_SEG_LG);
      ELEM_B2: return 3'(MIN_SEG_LG + 1);
      default: return 3'(MAX_SEG_LG);
    endcase
  endfunction
endpackage

// File: rtl/coal_cfg.sv
module coal_cfg #(
  parameter int LANE_W         = 5,
  parameter int GW             = 3,
  parameter int LEGACY_PARTS   = 2,
  parameter int UNCACHED_PARTS = 4
) (
  input  coal_pkg::elem_e elem_i,
  input  logic            cache_aware_i,
  input  logic            l1_bypass_i,
  input  logic            cop_global_i,
  output logic [GW-1:0]   grp_lg_o,
  output logic [2:0]      seg_lg_o
);
  import coal_pkg::*;

  localparam int LEG_LG = $clog2(LEGACY_PARTS);
  localparam int UNC_LG = $clog2(UNCACHED_PARTS);

  always_comb begin
    seg_lg_o = seg_lg_of(elem_i);
    // byte elements always merge across the whole warp
    if (elem_i == ELEM_B1)                 grp_lg_o = GW'(LANE_W);
    else if (!cache_aware_i)               grp_lg_o = GW'(LANE_W - LEG_LG);
    else if (l1_bypass_i || cop_global_i)  grp_lg_o = GW'(LANE_W - UNC_LG);
    else                                   grp_lg_o = GW'(LANE_W);
  end
endmodule

// File: rtl/coal_merge.sv
module coal_merge #(
  parameter int LANES  = 32,
  parameter int AW     = 32,
  parameter int LANE_W = 5,
  parameter int GW     = 3
) (
  input  logic [LANES*AW-1:0]            addr_i,
  input  logic [LANES-1:0]               pend_i,
  input  coal_pkg::elem_e                elem_i,
  input  logic [GW-1:0]                  grp_lg_i,
  input  logic [2:0]                     seg_lg_i,
  output logic [AW-1:0]                  base_o,
  output logic [LANES-1:0]               hit_o,
  output logic [coal_pkg::SEG_BYTES-1:0] bytes_o
);
  import coal_pkg::*;

  localparam int OW  = MAX_SEG_LG;
  localparam int LW1 = LANE_W + 1;

  logic [LANE_W-1:0]    lead;
  logic [AW-1:0]        lo_mask;
  logic [AW-1:0]        lead_addr;
  logic [LW1-1:0]       lead_grp;
  logic [SEG_BYTES-1:0] elem_ones;
  logic [SEG_BYTES-1:0] seg_ones;
  logic [SEG_BYTES-1:0] lane_bytes [LANES];

  // lowest pending lane leads; its group and segment select the merge set
  always_comb begin
    lead = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend_i[i]) lead = LANE_W'(i);
    end
  end

  assign lo_mask   = (AW'(1) << seg_lg_i) - AW'(1);
  assign lead_addr = addr_i[lead*AW +: AW];
  assign base_o    = lead_addr & ~lo_mask;
  assign lead_grp  = {1'b0, lead} >> grp_lg_i;
  assign elem_ones = (SEG_BYTES'(1) << (4'd1 << elem_i)) - SEG_BYTES'(1);
  assign seg_ones  = (SEG_BYTES'(1) << (8'd1 << seg_lg_i)) - SEG_BYTES'(1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [AW-1:0]  a;
    logic [LW1-1:0] grp;
    logic [OW-1:0]  off;
    assign a     = addr_i[g*AW +: AW];
    assign grp   = LW1'(g) >> grp_lg_i;
    assign hit_o[g] = pend_i[g] && (grp == lead_grp) && ((a & ~lo_mask) == base_o);
    assign off   = a[OW-1:0] & lo_mask[OW-1:0];
    assign lane_bytes[g] = hit_o[g] ? ((elem_ones << off) & seg_ones) : '0;
  end

  always_comb begin
    bytes_o = '0;
    for (int i = 0; i < LANES; i++) bytes_o |= lane_bytes[i];
  end
endmodule

// File: rtl/coal_shrink.sv
module coal_shrink #(
  parameter int AW = 32
) (
  input  logic [AW-1:0]                    base_i,
  input  logic [2:0]                       seg_lg_i,
  input  logic [coal_pkg::SEG_BYTES-1:0]   bytes_i,
  output logic [AW-1:0]                    addr_o,
  output logic [coal_pkg::MAX_SEG_LG:0]    size_o,
  output logic [coal_pkg::SEG_BYTES-1:0]   bytes_o
);
  import coal_pkg::*;

  logic [2:0]           lg;
  logic [7:0]           hb;
  logic [SEG_BYTES-1:0] half;

  always_comb begin
    addr_o  = base_i;
    bytes_o = bytes_i;
    lg      = seg_lg_i;
    hb      = '0;
    half    = '0;
    for (int s = 0; s < MAX_SEG_LG - MIN_SEG_LG; s++) begin
      if (lg > 3'(MIN_SEG_LG)) begin
        hb   = 8'd1 << (lg - 3'd1);
        half = (SEG_BYTES'(1) << hb) - SEG_BYTES'(1);
        if (((bytes_o >> hb) & half) == '0) begin
          lg = lg - 3'd1;
        end else if ((bytes_o & half) == '0) begin
          lg      = lg - 3'd1;
          addr_o  = addr_o + AW'(hb);
          bytes_o = bytes_o >> hb;
        end
      end
    end
    size_o = (MAX_SEG_LG+1)'(1) << lg;
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer import coal_pkg::*; #(
  parameter int LANES          = 32,
  parameter int AW             = 32,
  parameter int LEGACY_PARTS   = 2,
  parameter int UNCACHED_PARTS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [LANES*AW-1:0]   req_addr_i,
  input  logic [LANES-1:0]      req_active_i,
  input  logic [1:0]            req_elem_i,
  input  logic                  req_cache_aware_i,
  input  logic                  req_l1_bypass_i,
  input  logic                  req_cop_global_i,
  output logic                  busy_o,
  output logic                  txn_valid_o,
  input  logic                  txn_ready_i,
  output logic [AW-1:0]         txn_addr_o,
  output logic [MAX_SEG_LG:0]   txn_size_o,
  output logic [LANES-1:0]      txn_lanes_o,
  output logic [SEG_BYTES-1:0]  txn_bytes_o,
  output logic                  txn_done_o
);
  localparam int LANE_W = $clog2(LANES);
  localparam int GW     = $clog2(LANE_W + 1);

  logic [LANES*AW-1:0]  addr_q;
  logic [LANES-1:0]     pend_q;
  elem_e                elem_q;
  logic [GW-1:0]        grp_lg_q, grp_lg_d;
  logic [2:0]           seg_lg_q, seg_lg_d;
  logic [AW-1:0]        seg_base;
  logic [LANES-1:0]     hit;
  logic [SEG_BYTES-1:0] seg_bytes;
  logic                 accept, fire;

  coal_cfg #(
    .LANE_W(LANE_W), .GW(GW),
    .LEGACY_PARTS(LEGACY_PARTS), .UNCACHED_PARTS(UNCACHED_PARTS)
  ) u_cfg (
    .elem_i        (elem_e'(req_elem_i)),
    .cache_aware_i (req_cache_aware_i),
    .l1_bypass_i   (req_l1_bypass_i),
    .cop_global_i  (req_cop_global_i),
    .grp_lg_o      (grp_lg_d),
    .seg_lg_o      (seg_lg_d)
  );

  coal_merge #(.LANES(LANES), .AW(AW), .LANE_W(LANE_W), .GW(GW)) u_merge (
    .addr_i   (addr_q),
    .pend_i   (pend_q),
    .elem_i   (elem_q),
    .grp_lg_i (grp_lg_q),
    .seg_lg_i (seg_lg_q),
    .base_o   (seg_base),
    .hit_o    (hit),
    .bytes_o  (seg_bytes)
  );

  coal_shrink #(.AW(AW)) u_shrink (
    .base_i   (seg_base),
    .seg_lg_i (seg_lg_q),
    .bytes_i  (seg_bytes),
    .addr_o   (txn_addr_o),
    .size_o   (txn_size_o),
    .bytes_o  (txn_bytes_o)
  );

  assign busy_o      = |pend_q;
  assign txn_valid_o = busy_o;
  assign txn_lanes_o = hit;
  assign txn_done_o  = busy_o && ((pend_q & ~hit) == '0);
  assign accept      = req_valid_i && !busy_o;
  assign fire        = txn_valid_o && txn_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      pend_q   <= '0;
      elem_q   <= ELEM_B1;
      grp_lg_q <= '0;
      seg_lg_q <= '0;
    end else if (accept) begin
      addr_q   <= req_addr_i;
      pend_q   <= req_active_i;
      elem_q   <= elem_e'(req_elem_i);
      grp_lg_q <= grp_lg_d;
      seg_lg_q <= seg_lg_d;
    end else if (fire) begin
      pend_q <= pend_q & ~hit;
    end
  end
endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic                                busy_o,
  input logic                                txn_valid_o,
  input logic                                txn_ready_i,
  input logic [AW-1:0]                       txn_addr_o,
  input logic [coal_pkg::MAX_SEG_LG:0]       txn_size_o,
  input logic [LANES-1:0]                    txn_lanes_o,
  input logic [coal_pkg::SEG_BYTES-1:0]      txn_bytes_o,
  input logic                                txn_done_o
);
  AST_SIZE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> (txn_size_o == 8'd32 || txn_size_o == 8'd64 || txn_size_o == 8'd128)); // R2
  AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> ((txn_addr_o & (AW'(txn_size_o) - AW'(1))) == '0)); // R8
  AST_BYTES_FIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> ((txn_bytes_o >> txn_size_o) == '0)); // R7
  AST_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> (txn_lanes_o != '0 && txn_bytes_o != '0)); // R9
  AST_DONE_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_done_o |-> txn_valid_o); // R11
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_o && !txn_ready_i) |=> (txn_valid_o && $stable(txn_addr_o) && $stable(txn_size_o)
      && $stable(txn_lanes_o) && $stable(txn_bytes_o) && $stable(txn_done_o))); // R12
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_o && txn_ready_i && txn_done_o) |=> !busy_o); // R13
  AST_STAY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(txn_valid_o && txn_ready_i && txn_done_o)) |=> busy_o); // R13
endmodule

bind warp_coalescer warp_coalescer_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .txn_valid_o (txn_valid_o),
  .txn_ready_i (txn_ready_i),
  .txn_addr_o  (txn_addr_o),
  .txn_size_o  (txn_size_o),
  .txn_lanes_o (txn_lanes_o),
  .txn_bytes_o (txn_bytes_o),
  .txn_done_o  (txn_done_o)
);

// File: tb/warp_coalescer_test.sv
`timescale 1ns/1ps
module warp_coalescer_test;
  localparam int LANES = 32;
  localparam int AW    = 32;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 req_valid = 1'b0;
  logic [LANES*AW-1:0]  addr_v = '0;
  logic [LANES-1:0]     active = '0;
  logic [1:0]           elem = 2'd2;
  logic                 aware = 1'b0, byp = 1'b0, cop = 1'b0;
  logic                 busy, tv, tready = 1'b1, tdone;
  logic [AW-1:0]        taddr;
  logic [7:0]           tsize;
  logic [LANES-1:0]     tlanes;
  logic [127:0]         tbytes;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  warp_coalescer #(.LANES(LANES), .AW(AW), .LEGACY_PARTS(2), .UNCACHED_PARTS(4)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_addr_i(addr_v),
    .req_active_i(active), .req_elem_i(elem), .req_cache_aware_i(aware),
    .req_l1_bypass_i(byp), .req_cop_global_i(cop), .busy_o(busy), .txn_valid_o(tv),
    .txn_ready_i(tready), .txn_addr_o(taddr), .txn_size_o(tsize), .txn_lanes_o(tlanes),
    .txn_bytes_o(tbytes), .txn_done_o(tdone)
  );

  function automatic logic [127:0] ones(int n);
    return (128'(1) << n) - 128'(1);
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_lin(logic [31:0] base, int stride);
    for (int i = 0; i < LANES; i++) addr_v[i*AW +: AW] = base + 32'(stride * i);
  endtask

  task automatic set_split();
    for (int i = 0; i < LANES; i++)
      addr_v[i*AW +: AW] = (i % 2 == 0) ? 32'h4000 + 32'(2*i) : 32'h8000 + 32'(2*(i-1));
  endtask

  task automatic launch(logic [1:0] e, logic aw, logic b, logic c, logic [LANES-1:0] act);
    @(negedge clk);
    elem = e; aware = aw; byp = b; cop = c; active = act; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_txn(string tag, logic [31:0] a, int sz, logic [31:0] ln,
                            logic [127:0] by, logic dn);
    chk({tag, " valid"}, 128'(tv), 128'(1));
    chk({tag, " addr"},  128'(taddr), 128'(a));
    chk({tag, " size"},  128'(tsize), 128'(sz));
    chk({tag, " lanes"}, 128'(tlanes), 128'(ln));
    chk({tag, " bytes"}, tbytes, by);
    chk({tag, " done"},  128'(tdone), 128'(dn));
    @(negedge clk);
  endtask

  task automatic expect_idle(string tag);
    chk({tag, " busy"},  128'(busy), 128'(0));
    chk({tag, " valid"}, 128'(tv), 128'(0));
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    expect_idle("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    expect_idle("R1 after reset");
  endtask

  task automatic t_cached_full();  // R6
    set_lin(32'h1000, 4);
    launch(2'd2, 1'b1, 1'b0, 1'b0, '1);
    expect_txn("R6 cached one group", 32'h1000, 128, 32'hFFFF_FFFF, ones(128), 1'b1);
    expect_idle("R6 end");
  endtask

  task automatic t_bypass();  // R5 R8
    set_lin(32'h1000, 4);
    launch(2'd2, 1'b1, 1'b1, 1'b0, '1);
    expect_txn("R5 bypass g0", 32'h1000, 32, 32'h0000_00FF, ones(32), 1'b0);
    expect_txn("R8 bypass g1", 32'h1020, 32, 32'h0000_FF00, ones(32), 1'b0);
    expect_txn("R5 bypass g2", 32'h1040, 32, 32'h00FF_0000, ones(32), 1'b0);
    expect_txn("R11 bypass g3", 32'h1060, 32, 32'hFF00_0000, ones(32), 1'b1);
    expect_idle("R5 bypass end");
  endtask

  task automatic t_cop_global();  // R5
    set_lin(32'h1000, 4);
    launch(2'd2, 1'b1, 1'b0, 1'b1, '1);
    expect_txn("R5 cop g0", 32'h1000, 32, 32'h0000_00FF, ones(32), 1'b0);
    expect_txn("R5 cop g1", 32'h1020, 32, 32'h0000_FF00, ones(32), 1'b0);
    expect_txn("R5 cop g2", 32'h1040, 32, 32'h00FF_0000, ones(32), 1'b0);
    expect_txn("R5 cop g3", 32'h1060, 32, 32'hFF00_0000, ones(32), 1'b1);
  endtask

  task automatic t_legacy();  // R4 R8
    set_lin(32'h1000, 4);
    launch(2'd2, 1'b0, 1'b1, 1'b1, '1);
    expect_txn("R4 legacy lower half", 32'h1000, 64, 32'h0000_FFFF, ones(64), 1'b0);
    expect_txn("R8 legacy upper half", 32'h1040, 64, 32'hFFFF_0000, ones(64), 1'b1);
    expect_idle("R4 legacy end");
  endtask

  task automatic t_bytes();  // R2 R3
    set_lin(32'h2000, 1);
    launch(2'd0, 1'b0, 1'b0, 1'b0, '1);
    expect_txn("R3 byte legacy one group", 32'h2000, 32, 32'hFFFF_FFFF, ones(32), 1'b1);
    launch(2'd0, 1'b1, 1'b1, 1'b0, '1);
    expect_txn("R3 byte uncached one group", 32'h2000, 32, 32'hFFFF_FFFF, ones(32), 1'b1);
  endtask

  task automatic t_half_words();  // R2
    set_lin(32'h3000, 2);
    launch(2'd1, 1'b1, 1'b0, 1'b0, '1);
    expect_txn("R2 2B segment 64", 32'h3000, 64, 32'hFFFF_FFFF, ones(64), 1'b1);
  endtask

  task automatic t_double();  // R2 R7
    set_lin(32'h9000, 8);
    launch(2'd3, 1'b1, 1'b0, 1'b0, 32'h0000_FFFF);
    expect_txn("R7 8B elements", 32'h9000, 128, 32'h0000_FFFF, ones(128), 1'b1);
  endtask

  task automatic t_split();  // R7 R10
    set_split();
    launch(2'd2, 1'b1, 1'b0, 1'b0, '1);
    expect_txn("R10 even lanes first", 32'h4000, 64, 32'h5555_5555, ones(64), 1'b0);
    expect_txn("R7 odd lanes merged", 32'h8000, 64, 32'hAAAA_AAAA, ones(64), 1'b1);
  endtask

  task automatic t_quarter();  // R8
    addr_v = '0;
    addr_v[5*AW +: AW] = 32'h5064;
    launch(2'd2, 1'b1, 1'b0, 1'b0, 32'h0000_0020);
    expect_txn("R8 two-step narrowing", 32'h5060, 32, 32'h0000_0020, 128'hF0, 1'b1);
  endtask

  task automatic t_inactive();  // R9
    for (int i = 0; i < LANES; i++) addr_v[i*AW +: AW] = 32'hFFF0_0000 + 32'(i * 32'h200);
    addr_v[3*AW +: AW]  = 32'h6000;
    addr_v[20*AW +: AW] = 32'h6004;
    launch(2'd2, 1'b1, 1'b0, 1'b0, 32'h0010_0008);
    expect_txn("R9 inactive ignored", 32'h6000, 32, 32'h0010_0008, 128'hFF, 1'b1);
    expect_idle("R9 after sparse");
  endtask

  task automatic t_empty();  // R9
    set_lin(32'h1000, 4);
    launch(2'd2, 1'b1, 1'b0, 1'b0, '0);
    expect_idle("R9 empty warp");
    @(negedge clk);
    expect_idle("R9 empty warp later");
  endtask

  task automatic t_skip_groups();  // R9 R10
    addr_v = '0;
    addr_v[0*AW +: AW]  = 32'h7000;
    addr_v[24*AW +: AW] = 32'h7060;
    launch(2'd2, 1'b1, 1'b1, 1'b0, 32'h0100_0001);
    expect_txn("R10 group0 first", 32'h7000, 32, 32'h0000_0001, 128'hF, 1'b0);
    expect_txn("R9 group3 after skipped groups", 32'h7060, 32, 32'h0100_0000, 128'hF, 1'b1);
    expect_idle("R9 skip end");
  endtask

  task automatic t_backpressure();  // R12 R13
    set_split();
    tready = 1'b0;
    launch(2'd2, 1'b1, 1'b0, 1'b0, '1);
    chk("R13 busy after accept", 128'(busy), 128'(1));
    chk("R12 first addr", 128'(taddr), 128'h4000);
    set_lin(32'hA000, 4);
    active = 32'h0000_000F;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 addr held", 128'(taddr), 128'h4000);
    chk("R12 lanes held", 128'(tlanes), 128'h5555_5555);
    chk("R12 size held", 128'(tsize), 128'd64);
    tready = 1'b1;
    expect_txn("R12 release 1", 32'h4000, 64, 32'h5555_5555, ones(64), 1'b0);
    expect_txn("R13 busy request dropped", 32'h8000, 64, 32'hAAAA_AAAA, ones(64), 1'b1);
    expect_idle("R13 idle after drop");
  endtask

  initial begin
    t_reset();
    t_cached_full();
    t_bypass();
    t_cop_global();
    t_legacy();
    t_bytes();
    t_half_words();
    t_double();
    t_split();
    t_quarter();
    t_inactive();
    t_empty();
    t_skip_groups();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule